// File: doc/BRIEF.md
# Per-Processor Compare Timer

This block keeps one shared 32-bit up-counter for a cluster of processors, with a compare register for each processor. When the shared count equals a processor's compare value, that processor's compare-pending flag is raised. If the processor has unmasked its compare source, the flag appears on one of that processor's interrupt pins. Each processor's compare routing register chooses the pin, and a route-enable flag gates it. Software can halt the counter, and it can load a new count only while the counter is halted.

All control goes through a simple request port. Each request carries the index of the processor that issues it. Each processor sees its own registers through a local window. A second window reaches the registers of another processor, picked by a redirect index that the issuing processor stores. A read request returns its data on `rsp_rdata` one cycle later.

Word address map (`req_addr[5:4]` selects the window, `req_addr[3:0]` the register):
- Window 0 holds the shared registers: 0 = config (bit 0 halts the counter), 1 = count, 2 = count high word.
- Window 1 (local) and window 2 (redirected) hold the per-processor registers: 0 = control, 1 = pending (bit 1 is compare-pending), 2 = mask, 3 = mask clear, 4 = mask set, 5 = routing (bit 31 is route-enable, bits 5:0 are the pin number), 6 = redirect index, 7 = identity, 8 = compare, 9 = compare high word.
- Window 3 reads as 0.

Top module: `pct_top`

## Requirements
- R1: After reset the following hold: count is 0 and running, config reads 0, each compare reads 0xFFFFFFFF, each mask reads 0x32, each pending and control reads 0, each routing register reads 0x80000000, each redirect index reads 0, and all interrupt pins are low.
- R2: While config bit 0 is 0, the count rises by one every cycle. Writing config bit 0 = 1 halts it from the next cycle on. Writing 0 resumes counting. Config reads back the stored bit in bit 0.
- R3: A write to the count register loads the count only if the counter was halted when the write arrived. A write to the count register while the counter runs is ignored.
- R4: The count-high and compare-high registers always read 0. The control register always reads 0, and writes to it are ignored.
- R5: When the count equals a processor's compare value, pending bit 1 of that processor reads 1 from the next cycle on. The processor's pin number (routing bits 5:0) is driven high on `irq_o[proc*NUM_PINS + pin]` exactly when pending bit 1, mask bit 1 and routing bit 31 are all 1. Clearing mask bit 1 lowers the pin and leaves pending set.
- R6: A compare write clears that processor's pending bit 1 in the same cycle. The clear wins over a match in that cycle, so the pending bit reads 0 in the cycle after the write. If the count still equals the new compare value, the bit sets again one cycle later.
- R7: Writing the mask-set register ORs wdata bits 5:0 into the mask. Writing the mask-clear register clears the mask bits that are 1 in wdata bits 5:0. Mask bits above bit 5 always read 0.
- R8: A routing write stores bit 31 and bits 5:0, but only if bits 5:0 are below NUM_PINS. Otherwise the whole write is ignored.
- R9: An access in window 2 goes to the processor named by the issuing processor's redirect index. A redirect-index write of a value at or above NUM_PROC is ignored.
- R10: The identity register reads the index of the processor it addresses. That is the issuing processor in window 1 and the redirect target in window 2.
- R11: Read data appears on `rsp_rdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_proc | input | IDX_W | Index of the issuing processor |
| req_addr | input | 6 | Word address (window, register) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| irq_o | output | NUM_PROC*NUM_PINS | Interrupt pins, NUM_PINS per processor |

## Verification
A write changes register state at the edge where it is presented. Routing, mask and compare writes show on `irq_o` from the next cycle, because the pins are combinational on registered state. A count match shows on pending, and so on the pin, one cycle after the count equals the compare value. Read data is due one cycle after the request. The bench drives each request at a falling edge. It advances its behavioural model on the rising edge and compares `irq_o` with the model at every falling edge. It checks `rsp_rdata` at the falling edge that follows a read, both against the model and against values worked out by hand for each requirement. The count-load and compare-clear cases line up their requests so that the halted count and the match fall on known edges.

// File: rtl/pct_pkg.sv
// Package: shared constants for the per-processor compare timer.
// Assumes a 6-bit word address: two window bits above four register bits.
package pct_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 6;
    localparam int unsigned MASK_W      = 6;
    localparam int unsigned PIN_FIELD_W = 6;
    localparam int unsigned CMP_BIT     = 1;
    localparam int unsigned ROUTE_BIT   = 31;
    localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

    localparam logic [1:0] WIN_SHARED = 2'd0;
    localparam logic [1:0] WIN_LOCAL  = 2'd1;
    localparam logic [1:0] WIN_REDIR  = 2'd2;

    localparam logic [3:0] SH_CONFIG  = 4'd0;
    localparam logic [3:0] SH_COUNT   = 4'd1;
    localparam logic [3:0] SH_COUNTHI = 4'd2;

    localparam logic [3:0] PR_CTRL    = 4'd0;
    localparam logic [3:0] PR_PEND    = 4'd1;
    localparam logic [3:0] PR_MASK    = 4'd2;
    localparam logic [3:0] PR_MCLR    = 4'd3;
    localparam logic [3:0] PR_MSET    = 4'd4;
    localparam logic [3:0] PR_ROUTE   = 4'd5;
    localparam logic [3:0] PR_REDIR   = 4'd6;
    localparam logic [3:0] PR_IDENT   = 4'd7;
    localparam logic [3:0] PR_CMP     = 4'd8;
    localparam logic [3:0] PR_CMPHI   = 4'd9;
endpackage

// File: rtl/pct_counter.sv
// Shared counter with a halt control.
// Assumes at most one register write per cycle. A load is honoured only
// when the halt bit was already set at that edge.
module pct_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_halt,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             halted
);
    // Halt bit: follows the config write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      halted <= 1'b0;
        else if (cfg_wr) halted <= cfg_halt;
    end

    // Count: loads when halted, increments when running.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (cnt_wr && halted) cnt <= cnt_wdata;
        else if (!halted)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pct_slot.sv
// Per-processor state: compare value, compare-pending flag, local mask,
// routing register and redirect index, plus the pin decode.
// Assumes wr_en is already qualified for this processor.
module pct_slot
    import pct_pkg::*;
#(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned NUM_PINS = 6,
    parameter int unsigned CNT_W    = 32,
    localparam int unsigned IDX_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [MASK_W-1:0] pend_o,
    output logic [MASK_W-1:0] mask_o,
    output logic [DATA_W-1:0] route_o,
    output logic [IDX_W-1:0]  redir_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [NUM_PINS-1:0] irq_o
);
    localparam int unsigned GAP_W = DATA_W - 1 - PIN_FIELD_W;

    logic                   pend_q;
    logic                   route_en_q;
    logic [PIN_FIELD_W-1:0] pin_q;

    // Compare value: loaded by a compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmp_o <= '1;
        else if (wr_en && wr_off == PR_CMP)  cmp_o <= wdata[CNT_W-1:0];
    end

    // Pending flag: a compare write clears it and wins over a match.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend_q <= 1'b0;
        else if (wr_en && wr_off == PR_CMP)  pend_q <= 1'b0;
        else if (cnt == cmp_o)               pend_q <= 1'b1;
    end

    // Mask: write-one-to-set and write-one-to-clear over the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_o <= MASK_RST;
        else if (wr_en && wr_off == PR_MSET) mask_o <= mask_o | wdata[MASK_W-1:0];
        else if (wr_en && wr_off == PR_MCLR) mask_o <= mask_o & ~wdata[MASK_W-1:0];
    end

    // Routing: a write whose pin number is out of range is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_en_q <= 1'b1;
            pin_q      <= '0;
        end else if (wr_en && wr_off == PR_ROUTE &&
                     32'(wdata[PIN_FIELD_W-1:0]) < NUM_PINS) begin
            route_en_q <= wdata[ROUTE_BIT];
            pin_q      <= wdata[PIN_FIELD_W-1:0];
        end
    end

    // Redirect index: a value outside the processor range is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) redir_o <= '0;
        else if (wr_en && wr_off == PR_REDIR && wdata < NUM_PROC)
            redir_o <= wdata[IDX_W-1:0];
    end

    // Register views built from the stored fields.
    always_comb begin
        pend_o          = '0;
        pend_o[CMP_BIT] = pend_q;
        route_o         = {route_en_q, {GAP_W{1'b0}}, pin_q};
    end

    // Pin decode: one line per pin, live when all three gates agree.
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assign irq_o[k] = pend_q && mask_o[CMP_BIT] && route_en_q &&
                          (pin_q == PIN_FIELD_W'(k));
    end
endmodule

// File: rtl/pct_top.sv
// Top of the per-processor compare timer: request decode, window
// redirection, read multiplexer and one slot per processor.
// Assumes one request per cycle; read data is registered.
module pct_top
    import pct_pkg::*;
#(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned NUM_PINS = 6,
    parameter int unsigned CNT_W    = 32,
    localparam int unsigned IDX_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [IDX_W-1:0]             req_proc,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [NUM_PROC*NUM_PINS-1:0] irq_o
);
    logic [1:0]        win;
    logic [3:0]        off;
    logic              wr_req;
    logic              slot_win;
    logic [IDX_W-1:0]  own_redir;
    logic [IDX_W-1:0]  tgt;
    logic [CNT_W-1:0]  cnt_w;
    logic              halted_w;
    logic [DATA_W-1:0] rd_next;

    logic [MASK_W-1:0] pend_a  [NUM_PROC];
    logic [MASK_W-1:0] mask_a  [NUM_PROC];
    logic [DATA_W-1:0] route_a [NUM_PROC];
    logic [IDX_W-1:0]  redir_a [NUM_PROC];
    logic [CNT_W-1:0]  cmp_a   [NUM_PROC];

    // Request split and target selection.
    always_comb begin
        win       = req_addr[5:4];
        off       = req_addr[3:0];
        wr_req    = req_valid && req_write;
        slot_win  = (win == WIN_LOCAL) || (win == WIN_REDIR);
        own_redir = '0;
        for (int i = 0; i < NUM_PROC; i++)
            if (req_proc == IDX_W'(i)) own_redir = redir_a[i];
        tgt = (win == WIN_REDIR) ? own_redir : req_proc;
    end

    pct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_req && win == WIN_SHARED && off == SH_CONFIG),
        .cfg_halt  (req_wdata[0]),
        .cnt_wr    (wr_req && win == WIN_SHARED && off == SH_COUNT),
        .cnt_wdata (req_wdata[CNT_W-1:0]),
        .cnt       (cnt_w),
        .halted    (halted_w)
    );

    for (genvar i = 0; i < NUM_PROC; i++) begin : g_slot
        pct_slot #(.NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_req && slot_win && tgt == IDX_W'(i)),
            .wr_off  (off),
            .wdata   (req_wdata),
            .cnt     (cnt_w),
            .pend_o  (pend_a[i]),
            .mask_o  (mask_a[i]),
            .route_o (route_a[i]),
            .redir_o (redir_a[i]),
            .cmp_o   (cmp_a[i]),
            .irq_o   (irq_o[i*NUM_PINS +: NUM_PINS])
        );
    end

    // Read multiplexer over the shared and per-processor registers.
    always_comb begin
        rd_next = '0;
        if (win == WIN_SHARED) begin
            if (off == SH_CONFIG)     rd_next = {{(DATA_W-1){1'b0}}, halted_w};
            else if (off == SH_COUNT) rd_next = DATA_W'(cnt_w);
        end else if (slot_win) begin
            for (int i = 0; i < NUM_PROC; i++) begin
                if (tgt == IDX_W'(i)) begin
                    case (off)
                        PR_PEND:  rd_next = DATA_W'(pend_a[i]);
                        PR_MASK:  rd_next = DATA_W'(mask_a[i]);
                        PR_ROUTE: rd_next = route_a[i];
                        PR_REDIR: rd_next = DATA_W'(redir_a[i]);
                        PR_IDENT: rd_next = DATA_W'(tgt);
                        PR_CMP:   rd_next = DATA_W'(cmp_a[i]);
                        default:  rd_next = '0;
                    endcase
                end
            end
        end
    end

    // Read data register: captured on a read, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rsp_rdata <= '0;
        else if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
endmodule

// File: rtl/pct_checker.sv
// Checker for pct_top: counter progress, pin exclusivity, compare-clear
// and reset quiet. Attached through the bind below.
module pct_checker
    import pct_pkg::*;
#(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned NUM_PINS = 6,
    parameter int unsigned CNT_W    = 32,
    localparam int unsigned IDX_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_write,
    input logic [IDX_W-1:0]             req_proc,
    input logic [ADDR_W-1:0]            req_addr,
    input logic [NUM_PROC*NUM_PINS-1:0] irq_o,
    input logic [CNT_W-1:0]             cnt_w,
    input logic                         halted_w
);
    logic                past_ok;
    logic                cnt_load_req;
    logic                local_cmp_req;
    logic [NUM_PROC-1:0] proc_any;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Request classes observed at the port.
    always_comb begin
        cnt_load_req  = req_valid && req_write && req_addr == {WIN_SHARED, SH_COUNT};
        local_cmp_req = req_valid && req_write && req_addr == {WIN_LOCAL, PR_CMP};
    end

    for (genvar i = 0; i < NUM_PROC; i++) begin : g_proc
        assign proc_any[i] = |irq_o[i*NUM_PINS +: NUM_PINS];

        AST_ONE_PIN_PER_PROC: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(irq_o[i*NUM_PINS +: NUM_PINS])); // R5
    end

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(halted_w)) |-> (cnt_w == $past(cnt_w) + 1'b1)); // R2

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(halted_w) && !$past(cnt_load_req)) |-> $stable(cnt_w)); // R3

    AST_CMP_WRITE_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        local_cmp_req |=> (proc_any[$past(req_proc)] == 1'b0)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (irq_o == '0)); // R1
endmodule

bind pct_top pct_checker #(.NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_proc  (req_proc),
    .req_addr  (req_addr),
    .irq_o     (irq_o),
    .cnt_w     (cnt_w),
    .halted_w  (halted_w)
);

// File: tb/pct_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model stepped on each rising edge, compared on each
// falling edge, plus directed reads with hand-derived expected values.
module pct_top_tb_top;
    import pct_pkg::*;
    localparam int NP = 4;
    localparam int NK = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_proc = '0;
    logic [5:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic [NP*NK-1:0] irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    pct_top #(.NUM_PROC(NP), .NUM_PINS(NK), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_proc(req_proc), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Model state
    bit [31:0] m_cnt;
    bit        m_halt;
    bit [31:0] m_cmp [NP];
    bit        m_pend [NP];
    bit [5:0]  m_mask [NP];
    bit        m_ren [NP];
    int        m_pin [NP];
    int        m_redir [NP];
    bit [31:0] m_rdata;
    bit        m_rd_seen;

    function automatic bit [31:0] mread(int win, int off, int tgt);
        if (win == 0) begin
            if (off == 0) return {31'd0, m_halt};
            if (off == 1) return m_cnt;
            return 0;
        end
        if (win == 3) return 0;
        case (off)
            1: return m_pend[tgt] ? 32'h2 : 32'h0;
            2: return {26'd0, m_mask[tgt]};
            5: return {m_ren[tgt], 25'd0, 6'(m_pin[tgt])};
            6: return 32'(m_redir[tgt]);
            7: return 32'(tgt);
            8: return m_cmp[tgt];
            default: return 0;
        endcase
    endfunction

    function automatic bit [NP*NK-1:0] mirq();
        bit [NP*NK-1:0] v = '0;
        for (int p = 0; p < NP; p++)
            if (m_pend[p] && m_mask[p][1] && m_ren[p]) v[p*NK + m_pin[p]] = 1'b1;
        return v;
    endfunction

    // Model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_halt = 0; m_rdata = 0; m_rd_seen = 0;
            for (int p = 0; p < NP; p++) begin
                m_cmp[p] = 32'hFFFF_FFFF; m_pend[p] = 0; m_mask[p] = 6'h32;
                m_ren[p] = 1; m_pin[p] = 0; m_redir[p] = 0;
            end
        end else begin
            automatic int win = int'(req_addr[5:4]);
            automatic int off = int'(req_addr[3:0]);
            automatic bit wr = req_valid && req_write;
            automatic bit [31:0] d = req_wdata;
            automatic bit old_halt = m_halt;
            automatic bit [31:0] old_cnt = m_cnt;
            automatic int tgt = (win == 2) ? m_redir[req_proc] : int'(req_proc);
            m_rd_seen = req_valid && !req_write;
            if (m_rd_seen) m_rdata = mread(win, off, tgt);
            for (int p = 0; p < NP; p++) if (old_cnt == m_cmp[p]) m_pend[p] = 1;
            if (!old_halt) m_cnt = old_cnt + 1;
            if (wr && win == 0) begin
                if (off == 0) m_halt = d[0];
                if (off == 1 && old_halt) m_cnt = d;
            end
            if (wr && (win == 1 || win == 2)) begin
                case (off)
                    3: m_mask[tgt] = m_mask[tgt] & ~d[5:0];
                    4: m_mask[tgt] = m_mask[tgt] | d[5:0];
                    5: if (d[5:0] < NK) begin m_ren[tgt] = d[31]; m_pin[tgt] = int'(d[5:0]); end
                    6: if (d < NP) m_redir[tgt] = int'(d);
                    8: begin m_cmp[tgt] = d; m_pend[tgt] = 0; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (irq_o !== mirq()) begin
                bad++;
                $display("FAIL R5 irq got=%h exp=%h", irq_o, mirq());
            end
            if (m_rd_seen) chk("R11 model", rsp_rdata, m_rdata);
        end
    end

    localparam logic [5:0] A_CFG   = {WIN_SHARED, SH_CONFIG};
    localparam logic [5:0] A_CNT   = {WIN_SHARED, SH_COUNT};
    localparam logic [5:0] A_CNTHI = {WIN_SHARED, SH_COUNTHI};

    function automatic logic [5:0] la(input logic [3:0] o); return {WIN_LOCAL, o}; endfunction
    function automatic logic [5:0] ra(input logic [3:0] o); return {WIN_REDIR, o}; endfunction

    task automatic wr(input int p, input logic [5:0] a, input logic [31:0] d);
        req_proc = 2'(p); req_addr = a; req_wdata = d; req_write = 1; req_valid = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input int p, input logic [5:0] a, output logic [31:0] v);
        req_proc = 2'(p); req_addr = a; req_write = 0; req_valid = 1;
        @(negedge clk);
        v = rsp_rdata;
        req_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        rd(0, A_CFG, v);          chk("R1 cfg", v, 0);
        rd(0, la(PR_MASK), v);    chk("R1 mask", v, 32'h32);
        rd(3, la(PR_PEND), v);    chk("R1 pend", v, 0);
        rd(1, la(PR_ROUTE), v);   chk("R1 route", v, 32'h8000_0000);
        rd(2, la(PR_CMP), v);     chk("R1 cmp", v, 32'hFFFF_FFFF);
        rd(2, la(PR_REDIR), v);   chk("R1 redir", v, 0);
        // R2 running and halting
        rd(0, A_CNT, v); rd(0, A_CNT, v2); chk("R2 step", v2 - v, 1);
        wr(0, A_CFG, 1);
        rd(0, A_CNT, v); rd(0, A_CNT, v2); chk("R2 halted", v2, v);
        rd(0, A_CFG, v);          chk("R2 cfg", v, 1);
        // R3 load while halted, ignore while running
        wr(0, A_CNT, 100);
        rd(0, A_CNT, v);          chk("R3 load", v, 100);
        wr(0, A_CFG, 0);
        wr(0, A_CNT, 5);
        rd(0, A_CNT, v);          chk("R3 ignored", v, 101);
        // R4 constant registers
        rd(0, A_CNTHI, v);        chk("R4 cnthi", v, 0);
        rd(1, la(PR_CMPHI), v);   chk("R4 cmphi", v, 0);
        wr(1, la(PR_CTRL), 32'hFF);
        rd(1, la(PR_CTRL), v);    chk("R4 ctrl", v, 0);
        // R7 mask set/clear
        wr(1, la(PR_MSET), 32'hFF);
        rd(1, la(PR_MASK), v);    chk("R7 set", v, 32'h3F);
        wr(1, la(PR_MCLR), 32'h30);
        rd(1, la(PR_MASK), v);    chk("R7 clr", v, 32'h0F);
        wr(1, la(PR_MCLR), 32'h02); wr(1, la(PR_MSET), 32'h02);
        rd(1, la(PR_MASK), v);    chk("R7 reset", v, 32'h0F);
        // R8 routing
        wr(1, la(PR_ROUTE), 32'h8000_0003);
        rd(1, la(PR_ROUTE), v);   chk("R8 store", v, 32'h8000_0003);
        wr(1, la(PR_ROUTE), 32'h8000_0009);
        rd(1, la(PR_ROUTE), v);   chk("R8 bad pin", v, 32'h8000_0003);
        wr(1, la(PR_ROUTE), 32'h8000_0002);
        // R5 match and gating
        wr(0, A_CFG, 1); wr(0, A_CNT, 1000);
        wr(1, la(PR_CMP), 1005); wr(0, A_CFG, 0);
        repeat (12) @(negedge clk);
        chk("R5 pin", 32'(irq_o), 32'(1) << 8);
        rd(1, la(PR_PEND), v);    chk("R5 pend", v, 2);
        wr(1, la(PR_MCLR), 32'h02);
        chk("R5 masked", 32'(irq_o), 0);
        rd(1, la(PR_PEND), v);    chk("R5 still pend", v, 2);
        wr(1, la(PR_MSET), 32'h02);
        wr(1, la(PR_ROUTE), 32'h0000_0002);
        chk("R5 route off", 32'(irq_o), 0);
        wr(1, la(PR_ROUTE), 32'h8000_0002);
        chk("R5 route on", 32'(irq_o), 32'(1) << 8);
        // R6 compare write clears, and wins over a match
        wr(1, la(PR_CMP), 32'hFFFF_0000);
        chk("R6 cleared", 32'(irq_o), 0);
        rd(1, la(PR_PEND), v);    chk("R6 pend", v, 0);
        wr(0, A_CFG, 1); wr(0, A_CNT, 2000);
        wr(0, la(PR_CMP), 2000);
        rd(0, la(PR_PEND), v);    chk("R6 clear wins", v, 0);
        rd(0, la(PR_PEND), v);    chk("R6 rematch", v, 2);
        wr(0, la(PR_CMP), 32'hFFFF_FFFF); wr(0, A_CFG, 0);
        // R9 redirect window
        wr(2, la(PR_REDIR), 3);
        rd(2, la(PR_REDIR), v);   chk("R9 redir", v, 3);
        wr(2, la(PR_REDIR), 4);
        rd(2, la(PR_REDIR), v);   chk("R9 redir range", v, 3);
        wr(2, ra(PR_MCLR), 32'h10);
        rd(3, la(PR_MASK), v);    chk("R9 remote", v, 32'h22);
        rd(2, la(PR_MASK), v);    chk("R9 own kept", v, 32'h32);
        // R10 identity
        rd(2, la(PR_IDENT), v);   chk("R10 local", v, 2);
        rd(2, ra(PR_IDENT), v);   chk("R10 redir", v, 3);
        rd(0, la(PR_IDENT), v);   chk("R10 p0", v, 0);
        // R11 hold
        repeat (2) @(negedge clk);
        chk("R11 hold", rsp_rdata, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule